// File: doc/BRIEF.md
# Level-Priority Interrupt Request Arbiter

The block gathers interrupt causes from a parameterised set of peripheral sources and hands one of them at a time to a processor core. Each source has a latched flag, an enable, and a programmable priority level. On every cycle the arbiter picks one winner among the eligible sources. It presents that winner as a request strobe together with a vector number and a level. The core answers with a single-cycle accept.

A flag stays set until software clears it. Losing sources keep waiting and are presented in turn as the winners are accepted. A source with a higher priority that becomes pending before the core accepts replaces the presented vector and level. An accepted source is marked in service and is skipped until software clears its flag. This keeps the core from seeing the same cause twice.

Top module: `lvl_irq_arb`

## Requirements
- R1: A one-cycle pulse on `cause_i[i]` sets the flag of source i at the next rising clock edge. The flag then stays set until a clear.
- R2: Source i is eligible only when its flag is set, `enable_i[i]` is 1, its 3-bit level `level_i[3*i +: 3]` is nonzero and it is not in service. A flag whose enable is 0 is kept and becomes eligible again once the enable returns to 1.
- R3: Among eligible sources, the one with the highest level is presented.
- R4: Among eligible sources that share the highest level, the one with the lowest index is presented.
- R5: The vector of source i is `VEC_BASE + i` on the 5-bit `vec_o`. The default `VEC_BASE` is 16, so with 8 sources the vectors run from 16 to 23. `lvl_o` carries the level of the presented source.
- R6: A higher-priority cause that arrives while a request waits unaccepted replaces `vec_o` and `lvl_o` from the clock edge that latches it. The displaced source stays pending.
- R7: `ack_i` high while `req_o` is high marks the presented source as in service at that edge. That source is then suppressed until `clear_i` for it. The next winner is presented from the same edge.
- R8: `clear_i[i]` clears the flag and the in-service mark of source i at the clock edge, so no request comes from it. When `cause_i[i]` is high in the same cycle, the flag stays set.
- R9: `req_o` is low, with `vec_o` and `lvl_o` at 0, in any cycle in which no source is eligible. This follows in the same cycle from a change on `enable_i` or `level_i`.
- R10: While `rst_ni` is low, all flags and in-service marks are cleared and `req_o` is low.
- R11: Pending sources that lose arbitration are presented one after another, in descending priority, as each earlier winner is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cause_i | input | NUM_SRC | Per-source cause pulse, sets the flag |
| enable_i | input | NUM_SRC | Per-source enable |
| level_i | input | NUM_SRC*LVL_W | Per-source priority level, source i at bits LVL_W*i upward |
| clear_i | input | NUM_SRC | Per-source software clear of flag and in-service mark |
| ack_i | input | 1 | Core accepts the presented request |
| req_o | output | 1 | Request strobe to the core |
| vec_o | output | VEC_W | Vector number of the presented source |
| lvl_o | output | LVL_W | Level of the presented source |

## Verification
The assertions assume that `ack_i` is raised only in a cycle where `req_o` is already high. They also assume `ack_i` lasts one cycle per accept. The property on accepted sources leaving the output further assumes that no clear arrives in the same cycle as the accept. The bench drives `ack_i` only on rows where the table expects a presented request and never pairs it with a clear. It keeps the level map fixed during the table walk and changes `enable_i` only at the falling edge. This leaves every input stable across the rising edge that the checks depend on.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int unsigned DEF_NUM_SRC  = 8;
  localparam int unsigned DEF_LVL_W    = 3;
  localparam int unsigned DEF_VEC_W    = 5;
  localparam int unsigned DEF_VEC_BASE = 16;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cause_i,
  input  logic             clear_i,
  input  logic             accept_i,
  input  logic             enable_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             elig_o
);
  logic flag_q, insvc_q;

  // a new cause wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (cause_i) flag_q <= 1'b1;
    else if (clear_i) flag_q <= 1'b0;
  end

  // clear wins over accept for the in-service mark
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) insvc_q <= 1'b0;
    else if (clear_i) insvc_q <= 1'b0;
    else if (accept_i) insvc_q <= 1'b1;
  end

  assign elig_o = flag_q && enable_i && (level_i != '0) && !insvc_q;
endmodule

// File: rtl/irq_win_sel.sv
module irq_win_sel #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0]       elig_i,
  input  logic [NUM_SRC*LVL_W-1:0] level_i,
  output logic                     valid_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic [LVL_W-1:0]         lvl_o
);
  // scan from the top index down; >= lets the lower index take ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig_i[i] && (level_i[i*LVL_W +: LVL_W] >= lvl_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = level_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/lvl_irq_arb.sv
module lvl_irq_arb
  import lvl_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC  = DEF_NUM_SRC,
  parameter int unsigned LVL_W    = DEF_LVL_W,
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned VEC_BASE = DEF_VEC_BASE
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       cause_i,
  input  logic [NUM_SRC-1:0]       enable_i,
  input  logic [NUM_SRC*LVL_W-1:0] level_i,
  input  logic [NUM_SRC-1:0]       clear_i,
  input  logic                     ack_i,
  output logic                     req_o,
  output logic [VEC_W-1:0]         vec_o,
  output logic [LVL_W-1:0]         lvl_o
);
  localparam int unsigned IDX_W = idx_width(NUM_SRC);

  logic [NUM_SRC-1:0] elig;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic [LVL_W-1:0]   win_lvl;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    irq_src_slot #(.LVL_W(LVL_W)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cause_i  (cause_i[g]),
      .clear_i  (clear_i[g]),
      .accept_i (ack_i && win_valid && (win_idx == IDX_W'(g))),
      .enable_i (enable_i[g]),
      .level_i  (level_i[g*LVL_W +: LVL_W]),
      .elig_o   (elig[g])
    );
  end

  irq_win_sel #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_sel (
    .elig_i  (elig),
    .level_i (level_i),
    .valid_o (win_valid),
    .idx_o   (win_idx),
    .lvl_o   (win_lvl)
  );

  assign req_o = win_valid;
  assign vec_o = win_valid ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx)) : '0;
  assign lvl_o = win_valid ? win_lvl : '0;
endmodule

// File: rtl/lvl_irq_arb_chk.sv
module lvl_irq_arb_chk #(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned VEC_W    = 5,
  parameter int unsigned VEC_BASE = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_SRC-1:0]       cause_i,
  input logic [NUM_SRC-1:0]       clear_i,
  input logic [NUM_SRC*LVL_W-1:0] level_i,
  input logic                     ack_i,
  input logic [NUM_SRC-1:0]       elig,
  input logic                     req_o,
  input logic [VEC_W-1:0]         vec_o,
  input logic [LVL_W-1:0]         lvl_o
);
  p_req_lvl_nz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (lvl_o != '0));

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (vec_o == '0 && lvl_o == '0));

  p_vec_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (vec_o >= VEC_W'(VEC_BASE) && vec_o < VEC_W'(VEC_BASE + NUM_SRC)));

  p_ack_moves_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && clear_i == '0) |=> !(req_o && vec_o == $past(vec_o)));

  for (genvar j = 0; j < NUM_SRC; j++) begin : g_src
    localparam logic [VEC_W-1:0] VJ = VEC_W'(VEC_BASE + j);

    p_lvl_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      elig[j] |-> (req_o && level_i[j*LVL_W +: LVL_W] <= lvl_o));

    p_tie_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elig[j] && level_i[j*LVL_W +: LVL_W] == lvl_o) |-> (vec_o <= VJ));

    p_clear_kills_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clear_i[j] && !cause_i[j]) |=> !(req_o && vec_o == VJ));
  end
endmodule

bind lvl_irq_arb lvl_irq_arb_chk #(
  .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cause_i (cause_i),
  .clear_i (clear_i),
  .level_i (level_i),
  .ack_i   (ack_i),
  .elig    (elig),
  .req_o   (req_o),
  .vec_o   (vec_o),
  .lvl_o   (lvl_o)
);

// File: tb/lvl_irq_arb_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_arb_tb_top;
  localparam int unsigned N = 8;

  typedef struct packed {
    logic [7:0] cause;
    logic [7:0] en;
    logic [7:0] clr;
    logic       ack;
    logic       req;
    logic [4:0] vec;
    logic [2:0] lvl;
    logic [7:0] rq;
  } row_t;

  // levels: s7=5 s6=3 s5=0 s4=7 s3=1 s2=5 s1=5 s0=2
  localparam logic [23:0] LVLS = {3'd5, 3'd3, 3'd0, 3'd7, 3'd1, 3'd5, 3'd5, 3'd2};

  localparam int NROW = 19;
  localparam row_t TBL [NROW] = '{
    '{8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 5'd0,  3'd0, 8'd9 },  // R9 idle
    '{8'h01, 8'hFF, 8'h00, 1'b0, 1'b1, 5'd16, 3'd2, 8'd1 },  // R1 latch s0
    '{8'h08, 8'hFF, 8'h00, 1'b0, 1'b1, 5'd16, 3'd2, 8'd3 },  // R3 s3 lower
    '{8'h04, 8'hFF, 8'h00, 1'b0, 1'b1, 5'd18, 3'd5, 8'd6 },  // R6 s2 preempts
    '{8'h02, 8'hFF, 8'h00, 1'b0, 1'b1, 5'd17, 3'd5, 8'd4 },  // R4 s1 tie lower idx
    '{8'h00, 8'hFF, 8'h00, 1'b1, 1'b1, 5'd18, 3'd5, 8'd7 },  // R7 accept s1
    '{8'h00, 8'hFF, 8'h00, 1'b1, 1'b1, 5'd16, 3'd2, 8'd11},  // R11 accept s2
    '{8'h00, 8'hFF, 8'h01, 1'b0, 1'b1, 5'd19, 3'd1, 8'd8 },  // R8 clear s0
    '{8'h00, 8'hF7, 8'h00, 1'b0, 1'b0, 5'd0,  3'd0, 8'd2 },  // R2 s3 disabled
    '{8'h00, 8'hFF, 8'h00, 1'b0, 1'b1, 5'd19, 3'd1, 8'd2 },  // R2 flag kept
    '{8'h20, 8'hFF, 8'h00, 1'b0, 1'b1, 5'd19, 3'd1, 8'd2 },  // R2 level 0 ignored
    '{8'h02, 8'hFF, 8'h02, 1'b0, 1'b1, 5'd17, 3'd5, 8'd8 },  // R8 cause beats clear
    '{8'h10, 8'hFF, 8'h00, 1'b0, 1'b1, 5'd20, 3'd7, 8'd3 },  // R3 s4 top level
    '{8'h80, 8'hFF, 8'h00, 1'b0, 1'b1, 5'd20, 3'd7, 8'd3 },  // R3 s7 lower
    '{8'h00, 8'hFF, 8'h00, 1'b1, 1'b1, 5'd17, 3'd5, 8'd4 },  // R4 s1 before s7
    '{8'h00, 8'hFF, 8'h00, 1'b1, 1'b1, 5'd23, 3'd5, 8'd5 },  // R5 top vector
    '{8'h00, 8'hFF, 8'h00, 1'b1, 1'b1, 5'd19, 3'd1, 8'd11},  // R11 s3 last
    '{8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 5'd0,  3'd0, 8'd9 },  // R9 only level-0 left
    '{8'h00, 8'hFF, 8'hFF, 1'b0, 1'b0, 5'd0,  3'd0, 8'd8 }   // R8 clear all
  };

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [N-1:0]   cause_i = '0, enable_i = '1, clear_i = '0;
  logic [N*3-1:0] level_i = LVLS;
  logic           ack_i = 1'b0;
  logic           req_o;
  logic [4:0]     vec_o;
  logic [2:0]     lvl_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  lvl_irq_arb dut_i (
    .clk_i, .rst_ni, .cause_i, .enable_i, .level_i, .clear_i, .ack_i,
    .req_o, .vec_o, .lvl_o
  );

  task automatic check(input string rq, input logic er, input logic [4:0] ev,
                       input logic [2:0] el);
    n_chk++;
    if (req_o !== er || vec_o !== ev || lvl_o !== el) begin
      n_err++;
      $display("FAIL %s: req/vec/lvl got %0b/%0d/%0d exp %0b/%0d/%0d",
               rq, req_o, vec_o, lvl_o, er, ev, el);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  initial begin
    #1 check("R10 reset", 1'b0, 5'd0, 3'd0);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int r = 0; r < NROW; r++) begin
      @(negedge clk_i);
      cause_i = TBL[r].cause; enable_i = TBL[r].en;
      clear_i = TBL[r].clr;   ack_i    = TBL[r].ack;
      @(posedge clk_i);
      #1 check($sformatf("R%0d row %0d", TBL[r].rq, r), TBL[r].req, TBL[r].vec, TBL[r].lvl);
    end
    @(negedge clk_i);
    cause_i = '0; clear_i = '0; ack_i = 1'b0; enable_i = '1;

    // R9: enable drop removes the request in the same cycle, no clock needed
    @(negedge clk_i) cause_i = 8'h40;
    @(negedge clk_i) cause_i = '0;
    check("R1 s6 latched", 1'b1, 5'd22, 3'd3);
    enable_i = 8'hBF;
    #0.5 check("R9 enable drop same cycle", 1'b0, 5'd0, 3'd0);
    enable_i = '1;
    #0.5 check("R2 enable restore", 1'b1, 5'd22, 3'd3);

    // R10: asynchronous reset while pending
    @(negedge clk_i) cause_i = 8'h11;
    @(negedge clk_i) cause_i = '0;
    check("R3 s4 over s6", 1'b1, 5'd20, 3'd7);
    rst_ni = 1'b0;
    #0.5 check("R10 async reset", 1'b0, 5'd0, 3'd0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i) check("R10 flags gone", 1'b0, 5'd0, 3'd0);

    // R8: clear of the only pending source idles the output
    @(negedge clk_i) cause_i = 8'h01;
    @(negedge clk_i) begin cause_i = '0; clear_i = 8'h01; end
    @(negedge clk_i) clear_i = '0;
    check("R8 sole clear", 1'b0, 5'd0, 3'd0);

    summary();
  end
endmodule